// File: doc/BRIEF.md
# Reset-Cause Register with Guarded Debug-Port Disable

This block is an 8-bit control and status register on a simple processor bus. It keeps a record of the event that caused the most recent system reset. There are five possible causes: power-on, the external reset pin, brown-out, watchdog timeout, and a reset requested through the JTAG debug port. Each cause arrives as a one-cycle pulse from logic outside this block. Software reads the record, and it clears a cause by writing zero to that cause's bit.

The top bit of the register turns the JTAG debug port off. An accidental store must not be able to change it, so it takes a new value only when software writes that same value twice within a short window. The debug port is usable only when this bit is clear and the fuse that permits debugging is asserted. The reset sources, the debug port controller and the fuse storage are outside this block.

Top module: `rcr_status`

## Requirements
- R1: After the asynchronous reset, rd_data reads 8'h00 and dbg_enable follows fuse_dbg_en.
- R2: Register layout of rd_data: bit 7 is the debug-disable bit, bit 4 is the JTAG-request flag, bit 3 is the watchdog flag, bit 2 is the brown-out flag, bit 1 is the external flag and bit 0 is the power-on flag. Bits 6 and 5 always read 0, even after a write of 1 to them.
- R3: A single write leaves bit 7 unchanged, whatever value it carries.
- R4: A second write that carries the same bit-7 value as the first, presented 1 to 4 cycles after the first, sets bit 7 to that value. The new value can be read in the cycle after the second write.
- R5: A second write presented 5 or more cycles after the first does not change bit 7. Instead it opens a new window, which a third matching write can complete.
- R6: A write whose bit-7 value differs from the pending value does not change bit 7. It restarts the window with the new value as the pending value.
- R7: dbg_enable is 1 exactly when fuse_dbg_en is 1 and bit 7 is 0.
- R8: The ext_rst_pulse, wdt_rst_pulse and dbg_rst_pulse inputs each set their own flag and leave the other flags as they are.
- R9: A brown-out pulse sets bit 2 and clears bit 4.
- R10: A power-on pulse sets bit 0 and clears bits 4 to 1. It leaves bit 7 as it is.
- R11: A write clears each flag in bits 4 to 0 whose data bit is 0. It leaves unchanged each flag whose data bit is 1.
- R12: When a reset pulse and a clearing write fall in the same cycle, the flag set by the pulse ends up 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write strobe for this register |
| wr_data | input | 8 | Bus write data |
| rd_data | output | 8 | Current register value |
| por_pulse | input | 1 | Power-on reset event, one cycle |
| ext_rst_pulse | input | 1 | External pin reset event, one cycle |
| bor_pulse | input | 1 | Brown-out reset event, one cycle |
| wdt_rst_pulse | input | 1 | Watchdog reset event, one cycle |
| dbg_rst_pulse | input | 1 | Debug-port reset request event, one cycle |
| fuse_dbg_en | input | 1 | Fuse permitting the debug port |
| dbg_enable | output | 1 | Debug port enabled |

## Verification
A software write that clears flags can land in the same cycle as an incoming reset pulse. Both act on the same flag register. The bench drives a write of all zeros and an external reset pulse on the same clock edge. It then requires the external flag to read 1 while every other flag reads 0. A similar overlap occurs when a flag-clearing write also counts toward the timed bit-7 sequence. Every such write carries the bit-7 value expected at that point, so a commit it triggers leaves the value the bench predicts.

// File: rtl/rcr_pkg.sv
package rcr_pkg;
  localparam int REG_W    = 8;
  localparam int FLAG_W   = 5;
  localparam int DIS_BIT  = 7;
  localparam int F_POR    = 0;
  localparam int F_EXT    = 1;
  localparam int F_BOR    = 2;
  localparam int F_WDT    = 3;
  localparam int F_DBG    = 4;

  typedef struct packed {
    logic dbg;
    logic wdt;
    logic bor;
    logic ext;
    logic por;
  } rst_src_t;
endpackage

// File: rtl/rcr_timed_bit.sv
module rcr_timed_bit #(
  parameter int WIN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_val,
  output logic bit_q
);
  localparam int CNT_W = (WIN > 1) ? $clog2(WIN) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WIN - 1);

  logic             armed_q, armed_n;
  logic             pend_q, pend_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             bit_n;
  logic             upd_en;

  // next state: the first write arms the window, and a matching second write commits
  always_comb begin
    bit_n   = bit_q;
    armed_n = armed_q;
    pend_n  = pend_q;
    cnt_n   = cnt_q;
    if (wr_en) begin
      if (armed_q && (wr_val == pend_q)) begin
        bit_n   = wr_val;
        armed_n = 1'b0;
      end else begin
        armed_n = 1'b1;
        pend_n  = wr_val;
        cnt_n   = CNT_LOAD;
      end
    end else if (armed_q) begin
      if (cnt_q == '0) armed_n = 1'b0;
      else             cnt_n   = cnt_q - 1'b1;
    end
  end

  assign upd_en = wr_en | armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q   <= 1'b0;
      armed_q <= 1'b0;
      pend_q  <= 1'b0;
      cnt_q   <= '0;
    end else if (upd_en) begin
      bit_q   <= bit_n;
      armed_q <= armed_n;
      pend_q  <= pend_n;
      cnt_q   <= cnt_n;
    end
  end

  AST_BIT_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_q != $past(bit_q)) |-> $past(wr_en)); // R3
  AST_BIT_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_q != $past(bit_q)) |-> ($past(armed_q) && ($past(wr_val) == $past(pend_q)))); // R4
  AST_WINDOW_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && (cnt_q == '0) && !wr_en) |=> !armed_q); // R5
endmodule

// File: rtl/rcr_flags.sv
module rcr_flags
  import rcr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [FLAG_W-1:0] wr_flags,
  input  rst_src_t          src,
  output logic [FLAG_W-1:0] flags_q
);
  logic [FLAG_W-1:0] flags_n;
  logic              upd_en;

  // priority, lowest first: software clear, then the set pulses, then brown-out, then power-on
  always_comb begin
    flags_n = flags_q;
    if (wr_en) flags_n = flags_n & wr_flags;
    if (src.ext) flags_n[F_EXT] = 1'b1;
    if (src.wdt) flags_n[F_WDT] = 1'b1;
    if (src.dbg) flags_n[F_DBG] = 1'b1;
    if (src.bor) begin
      flags_n[F_BOR] = 1'b1;
      flags_n[F_DBG] = 1'b0;
    end
    if (src.por) begin
      flags_n        = '0;
      flags_n[F_POR] = 1'b1;
    end
  end

  assign upd_en = wr_en | (|src);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flags_q <= '0;
    else if (upd_en) flags_q <= flags_n;
  end

  AST_POR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(src.por) |-> (flags_q == FLAG_W'(1))); // R10
  AST_BOR_CLEARS_DBG: assert property (@(posedge clk) disable iff (!rst_n)
    $past(src.bor && !src.por) |-> (flags_q[F_BOR] && !flags_q[F_DBG])); // R9
  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $past(src.ext && !src.por && wr_en) |-> flags_q[F_EXT]); // R12
endmodule

// File: rtl/rcr_status.sv
module rcr_status
  import rcr_pkg::*;
#(
  parameter int WIN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             por_pulse,
  input  logic             ext_rst_pulse,
  input  logic             bor_pulse,
  input  logic             wdt_rst_pulse,
  input  logic             dbg_rst_pulse,
  input  logic             fuse_dbg_en,
  output logic             dbg_enable
);
  rst_src_t          src;
  logic [FLAG_W-1:0] flags;
  logic              dis;

  assign src.por = por_pulse;
  assign src.ext = ext_rst_pulse;
  assign src.bor = bor_pulse;
  assign src.wdt = wdt_rst_pulse;
  assign src.dbg = dbg_rst_pulse;

  rcr_timed_bit #(.WIN(WIN)) u_dis (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_val (wr_data[DIS_BIT]),
    .bit_q  (dis)
  );

  rcr_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_flags (wr_data[FLAG_W-1:0]),
    .src      (src),
    .flags_q  (flags)
  );

  always_comb begin
    rd_data               = '0;
    rd_data[FLAG_W-1:0]   = flags;
    rd_data[DIS_BIT]      = dis;
  end

  assign dbg_enable = fuse_dbg_en & ~dis;

  AST_DBG_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_enable |-> (fuse_dbg_en && !rd_data[DIS_BIT])); // R7
endmodule

// File: tb/sim_rcr_status.sv
module sim_rcr_status;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic       por_pulse, ext_rst_pulse, bor_pulse, wdt_rst_pulse, dbg_rst_pulse;
  logic       fuse_dbg_en;
  logic       dbg_enable;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  rcr_status u0 (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .wr_data       (wr_data),
    .rd_data       (rd_data),
    .por_pulse     (por_pulse),
    .ext_rst_pulse (ext_rst_pulse),
    .bor_pulse     (bor_pulse),
    .wdt_rst_pulse (wdt_rst_pulse),
    .dbg_rst_pulse (dbg_rst_pulse),
    .fuse_dbg_en   (fuse_dbg_en),
    .dbg_enable    (dbg_enable)
  );

  task automatic chk_rd(input string req, input logic [7:0] exp);
    n_chk++;
    if (rd_data !== exp) begin
      n_err++;
      $display("FAIL %s: rd_data=%h expected=%h", req, rd_data, exp);
    end
  endtask

  task automatic chk_en(input string req, input logic exp);
    n_chk++;
    if (dbg_enable !== exp) begin
      n_err++;
      $display("FAIL %s: dbg_enable=%b expected=%b", req, dbg_enable, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  // sel: 0 por, 1 ext, 2 bor, 3 wdt, 4 dbg
  task automatic pulse(input int sel);
    por_pulse     = (sel == 0);
    ext_rst_pulse = (sel == 1);
    bor_pulse     = (sel == 2);
    wdt_rst_pulse = (sel == 3);
    dbg_rst_pulse = (sel == 4);
    @(negedge clk);
    por_pulse = 0; ext_rst_pulse = 0; bor_pulse = 0; wdt_rst_pulse = 0; dbg_rst_pulse = 0;
  endtask

  task automatic t_reset;
    chk_rd("R1", 8'h00);
    chk_en("R1", 1'b1);
  endtask

  task automatic t_sources;
    pulse(1); chk_rd("R8 ext", 8'h02);
    pulse(3); chk_rd("R8 wdt", 8'h0A);
    pulse(4); chk_rd("R8 dbg", 8'h1A);
    pulse(2); chk_rd("R9 bor", 8'h0E);
  endtask

  task automatic t_sw_clear;
    idle(6);
    bus_wr(8'h6B); chk_rd("R11/R2 partial clear, bits 6:5 zero", 8'h0A);
    bus_wr(8'h00); chk_rd("R11 full clear", 8'h00);
  endtask

  task automatic t_por;
    pulse(1); pulse(3); pulse(4);
    chk_rd("R8 setup", 8'h1A);
    pulse(0); chk_rd("R10 por", 8'h01);
  endtask

  task automatic t_collide;
    idle(6);
    wr_en = 1'b1; wr_data = 8'h00; ext_rst_pulse = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; ext_rst_pulse = 1'b0;
    chk_rd("R12 pulse beats clear", 8'h02);
  endtask

  task automatic t_single;
    idle(6);
    bus_wr(8'h82); idle(6);
    chk_rd("R3 single write", 8'h02);
    chk_en("R3 single write", 1'b1);
  endtask

  task automatic t_double;
    for (int k = 1; k <= 4; k++) begin
      idle(6);
      bus_wr(8'h82); idle(k - 1); bus_wr(8'h82);
      chk_rd($sformatf("R4 gap %0d", k), 8'h82);
      idle(6);
      bus_wr(8'h02); bus_wr(8'h02);
      chk_rd("R4 restore", 8'h02);
    end
  endtask

  task automatic t_gap5;
    idle(6);
    bus_wr(8'h82); idle(4); bus_wr(8'h82);
    chk_rd("R5 gap 5 no change", 8'h02);
    bus_wr(8'h82);
    chk_rd("R5 new window commits", 8'h82);
    pulse(0);
    chk_rd("R10 por keeps bit 7", 8'h81);
    idle(6);
    bus_wr(8'h01); bus_wr(8'h01);
    chk_rd("R4 restore", 8'h01);
  endtask

  task automatic t_rearm;
    idle(6);
    bus_wr(8'h81); bus_wr(8'h01); bus_wr(8'h81);
    chk_rd("R6 differing writes", 8'h01);
    bus_wr(8'h81);
    chk_rd("R6 re-armed commit", 8'h81);
  endtask

  task automatic t_fuse;
    chk_en("R7 disabled, fuse 1", 1'b0);
    fuse_dbg_en = 1'b0; idle(1);
    chk_en("R7 disabled, fuse 0", 1'b0);
    idle(6);
    bus_wr(8'h01); bus_wr(8'h01);
    chk_rd("R4 restore", 8'h01);
    chk_en("R7 enabled bit, fuse 0", 1'b0);
    fuse_dbg_en = 1'b1; idle(1);
    chk_en("R7 enabled bit, fuse 1", 1'b1);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = 8'h00; fuse_dbg_en = 1'b1;
    por_pulse = 0; ext_rst_pulse = 0; bor_pulse = 0; wdt_rst_pulse = 0; dbg_rst_pulse = 0;
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_sources();
    t_sw_clear();
    t_por();
    t_collide();
    t_single();
    t_double();
    t_gap5();
    t_rearm();
    t_fuse();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule